// File: doc/BRIEF.md
# Translation Entry Invalidation Engine

This block is a self-timed command engine that removes stale I/O page table entries from a translation cache. Software writes a single 64-bit command word that packs an entry count, the physical address of the first 8-byte page table entry, and a go flag. The engine then walks the named entries, one per clock cycle, and presents each entry address on an invalidate strobe to the cache. When the last entry has been issued, it clears the go flag.

Software starts a command by writing the word with bit 0 set and then polls the same register until bit 0 reads back as 0. Ranges longer than one command can cover are split into several commands, each written once the previous one has completed. A write that lands while a command is still running is dropped, and a sticky error bit records it.

Top module: `xlat_inval_engine`

## Requirements
- R1: After reset, `rdData` reads 0 and `invValid` is low.
- R2: A write with bit 0 set, made while idle, sets the busy bit (bit 0 of `rdData`) on the next cycle, and strobes begin on that same cycle.
- R3: The first strobe carries the byte address held in command bits 41:3, with address bits 2:0 at zero.
- R4: Each following strobe carries the previous strobe address plus 8.
- R5: A command with count field N (bits 63:53, N from 1 to 2047) issues exactly N strobes on consecutive cycles. Busy reads 0 on the cycle after the last strobe.
- R6: A count field of 0 issues 2048 strobes.
- R7: A write with bit 0 clear, made while idle, stores the count and address fields and starts nothing: no strobe appears and busy stays 0.
- R8: A write made while busy has no effect. The strobe sequence and the stored count and address fields are unchanged.
- R9: A write made while busy sets the sticky error bit (bit 1 of `rdData`). Any write accepted while idle clears that bit.
- R10: `rdData` returns the stored count in bits 63:53, the stored address in bits 41:3, the error bit in bit 1 and the live busy bit in bit 0. Bits 52:42 and bit 2 read 0.
- R11: `invValid` is high exactly when the busy bit reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Command register write enable |
| wrData | input | 64 | Command word to write |
| rdData | output | 64 | Command register readback |
| invValid | output | 1 | Invalidate strobe to the translation cache |
| invAddr | output | 42 | Byte address of the entry to invalidate |

## Verification
Commands with random counts and random entry addresses are mixed with directed corner cases. The directed cases are a single entry, the largest explicit count and the zero count that stands for 2048. Together these tell apart off-by-one errors in the stop condition, a missing expansion of the zero count, and a wrong address at the start of a walk or at each step. Some commands receive a stray write at a random strobe cycle, including the final one. This shows whether the write is truly ignored and whether the error bit sets. Writes made while idle with the go bit clear confirm that fields load without starting a walk and that the sticky error clears.

// File: rtl/xlat_inval_pkg.sv
package xlat_inval_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic load;     // accepted write: capture fields
    logic start;    // accepted write with go bit
    logic step;     // one entry issued this cycle
    logic flagErr;  // write arrived while busy
  } invStrobes_t;
endpackage

// File: rtl/inval_ctrl.sv
module inval_ctrl
  import xlat_inval_pkg::*;
#(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             goBit,
  input  logic [CNT_W-1:0] cntField,
  output logic             busy,
  output logic             errFlag,
  output invStrobes_t      strobes
);
  localparam int REM_W = CNT_W + 1;
  localparam logic [REM_W-1:0] FULL_CNT = REM_W'(1) << CNT_W;

  logic [REM_W-1:0] remaining;
  logic [REM_W-1:0] startCnt;
  logic             lastEntry;

  always_comb begin
    strobes.load    = wrEn && !busy;
    strobes.start   = wrEn && !busy && goBit;
    strobes.step    = busy;
    strobes.flagErr = wrEn && busy;
  end

  assign startCnt  = (cntField == '0) ? FULL_CNT : {1'b0, cntField};
  assign lastEntry = busy && (remaining == REM_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy      <= 1'b0;
      remaining <= '0;
      errFlag   <= 1'b0;
    end else begin
      if (strobes.start) begin
        busy      <= 1'b1;
        remaining <= startCnt;
      end else if (strobes.step) begin
        remaining <= remaining - REM_W'(1);
        if (lastEntry) busy <= 1'b0;
      end
      if (strobes.flagErr)   errFlag <= 1'b1;
      else if (strobes.load) errFlag <= 1'b0;
    end
  end
endmodule

// File: rtl/inval_datapath.sv
module inval_datapath
  import xlat_inval_pkg::*;
#(
  parameter int WORD_W   = 64,
  parameter int CNT_W    = 11,
  parameter int CNT_LSB  = 53,
  parameter int ADDR_MSB = 41,
  parameter int ADDR_LSB = 3
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  invStrobes_t                  strobes,
  input  logic [CNT_W-1:0]             cntField,
  input  logic [ADDR_MSB-ADDR_LSB:0]   idxField,
  input  logic                         busy,
  input  logic                         errFlag,
  output logic [WORD_W-1:0]            rdData,
  output logic [ADDR_MSB:0]            invAddr
);
  localparam int IDX_W = ADDR_MSB - ADDR_LSB + 1;

  logic [CNT_W-1:0] cmdCnt;
  logic [IDX_W-1:0] cmdIdx;
  logic [IDX_W-1:0] cursor;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdCnt <= '0;
      cmdIdx <= '0;
      cursor <= '0;
    end else if (strobes.load) begin
      cmdCnt <= cntField;
      cmdIdx <= idxField;
      cursor <= idxField;
    end else if (strobes.step) begin
      cursor <= cursor + IDX_W'(1);
    end
  end

  always_comb begin
    invAddr = '0;
    invAddr[ADDR_MSB:ADDR_LSB] = cursor;
  end

  always_comb begin
    rdData = '0;
    rdData[CNT_LSB +: CNT_W]  = cmdCnt;
    rdData[ADDR_LSB +: IDX_W] = cmdIdx;
    rdData[1] = errFlag;
    rdData[0] = busy;
  end
endmodule

// File: rtl/xlat_inval_engine.sv
module xlat_inval_engine
  import xlat_inval_pkg::*;
#(
  parameter int WORD_W   = 64,
  parameter int CNT_W    = 11,
  parameter int CNT_LSB  = 53,
  parameter int ADDR_MSB = 41,
  parameter int ADDR_LSB = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [WORD_W-1:0] wrData,
  output logic [WORD_W-1:0] rdData,
  output logic              invValid,
  output logic [ADDR_MSB:0] invAddr
);
  invStrobes_t strobes;
  logic        busy;
  logic        errFlag;
  logic        wrUnused;

  // reserved command bits carry no meaning
  assign wrUnused = ^{wrData[CNT_LSB-1:ADDR_MSB+1], wrData[ADDR_LSB-1:1]};

  inval_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .goBit    (wrData[0]),
    .cntField (wrData[CNT_LSB +: CNT_W]),
    .busy     (busy),
    .errFlag  (errFlag),
    .strobes  (strobes)
  );

  inval_datapath #(
    .WORD_W(WORD_W), .CNT_W(CNT_W), .CNT_LSB(CNT_LSB),
    .ADDR_MSB(ADDR_MSB), .ADDR_LSB(ADDR_LSB)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .cntField (wrData[CNT_LSB +: CNT_W]),
    .idxField (wrData[ADDR_MSB:ADDR_LSB]),
    .busy     (busy),
    .errFlag  (errFlag),
    .rdData   (rdData),
    .invAddr  (invAddr)
  );

  assign invValid = busy;
endmodule

// File: rtl/xlat_inval_checker.sv
module xlat_inval_checker #(
  parameter int WORD_W   = 64,
  parameter int CNT_LSB  = 53,
  parameter int ADDR_MSB = 41,
  parameter int ADDR_LSB = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [WORD_W-1:0] wrData,
  input logic [WORD_W-1:0] rdData,
  input logic              invValid,
  input logic [ADDR_MSB:0] invAddr
);
  localparam int AW = ADDR_MSB + 1;
  localparam logic [AW-1:0] ENTRY_BYTES = AW'(1) << ADDR_LSB;

  a_r2_start: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !rdData[0] && wrData[0]) |=>
      (rdData[0] && invValid &&
       invAddr[ADDR_MSB:ADDR_LSB] == $past(wrData[ADDR_MSB:ADDR_LSB])));

  a_r4_stride: assert property (@(posedge clk) disable iff (!rstN)
    invValid |=> (!invValid || invAddr == $past(invAddr) + ENTRY_BYTES));

  a_r7_no_go: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !rdData[0] && !wrData[0]) |=> (!invValid && !rdData[0]));

  a_r8_fields_hold: assert property (@(posedge clk) disable iff (!rstN)
    rdData[0] |=> rdData[WORD_W-1:2] == $past(rdData[WORD_W-1:2]));

  a_r9_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && rdData[0]) |=> rdData[1]);

  a_r10_reserved: assert property (@(posedge clk) disable iff (!rstN)
    (rdData[CNT_LSB-1:ADDR_MSB+1] == '0) && !rdData[2]);

  a_r11_valid_busy: assert property (@(posedge clk) disable iff (!rstN)
    invValid == rdData[0]);
endmodule

bind xlat_inval_engine xlat_inval_checker #(
  .WORD_W(WORD_W), .CNT_LSB(CNT_LSB), .ADDR_MSB(ADDR_MSB), .ADDR_LSB(ADDR_LSB)
) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
  .rdData(rdData), .invValid(invValid), .invAddr(invAddr)
);

// File: tb/tb_xlat_inval_engine.sv
module tb_xlat_inval_engine;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [63:0] wrData = '0;
  logic [63:0] rdData;
  logic        invValid;
  logic [41:0] invAddr;
  int          errors = 0;
  int          checks = 0;
  bit          done = 0;

  always #5 clk = ~clk;

  xlat_inval_engine dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .invValid(invValid), .invAddr(invAddr)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mkCmd(input int cnt, input logic [38:0] idx, input bit go);
    logic [63:0] w = '0;
    w[63:53] = cnt[10:0];
    w[41:3]  = idx;
    w[0]     = go;
    return w;
  endfunction

  function automatic logic [63:0] expRd(input int cnt, input logic [38:0] idx,
                                        input bit err, input bit bsy);
    logic [63:0] w = mkCmd(cnt, idx, bsy);
    w[1] = err;
    return w;
  endfunction

  task automatic runCmd(input int cnt, input logic [38:0] idx, input int injectAt);
    int          expN = (cnt == 0) ? 2048 : cnt;
    int          seen = 0;
    bit          injected = 0;
    logic [41:0] expA = {idx, 3'b000};
    @(negedge clk);
    wrEn = 1'b1; wrData = mkCmd(cnt, idx, 1'b1);
    @(negedge clk);
    wrEn = 1'b0;
    // R2 R9 R10: busy up, error cleared by accepted write, fields visible
    check(rdData == expRd(cnt, idx, 1'b0, 1'b1), "R2/R9/R10 readback at start",
          rdData, expRd(cnt, idx, 1'b0, 1'b1));
    while (invValid && seen < 3000) begin
      check(invAddr == expA, (seen == 0) ? "R3 first address" : "R4 stride",
            64'(invAddr), 64'(expA));
      check(rdData[0] == 1'b1, "R11 busy with strobe", 64'(rdData[0]), 64'd1);
      seen++;
      expA = expA + 42'd8;
      if (seen - 1 == injectAt) begin
        wrEn = 1'b1;
        wrData = {$urandom, $urandom} | 64'd1;
        injected = 1;
      end else begin
        wrEn = 1'b0;
      end
      @(negedge clk);
    end
    wrEn = 1'b0;
    check(seen == expN, (cnt == 0) ? "R6 zero count is 2048" : "R5 strobe count",
          64'(seen), 64'(expN));
    // R8 R9: stray write ignored, sticky error set
    check(rdData == expRd(cnt, idx, injected, 1'b0), "R8/R9/R11 readback at end",
          rdData, expRd(cnt, idx, injected, 1'b0));
  endtask

  task automatic idleWrite(input int cnt, input logic [38:0] idx);
    @(negedge clk);
    wrEn = 1'b1; wrData = mkCmd(cnt, idx, 1'b0) | 64'h001F_FC00_0000_0006;
    @(negedge clk);
    wrEn = 1'b0;
    for (int k = 0; k < 3; k++) begin
      check(!invValid, "R7 no strobe without go", 64'(invValid), 64'd0);
      @(negedge clk);
    end
    check(rdData == expRd(cnt, idx, 1'b0, 1'b0), "R7/R9/R10 fields stored, error cleared",
          rdData, expRd(cnt, idx, 1'b0, 1'b0));
  endtask

  initial begin
    void'($urandom(32'h5eed_0017));
    repeat (3) @(negedge clk);
    check(rdData == 64'd0, "R1 reset readback", rdData, 64'd0);
    check(!invValid, "R1 reset strobe", 64'(invValid), 64'd0);
    rstN = 1'b1;
    @(negedge clk);

    idleWrite(5, 39'h12_3456_789A);
    runCmd(1, 39'h00_0000_0010, -1);
    runCmd(3, 39'h7F_FFFF_FF00, 2);       // stray write on final strobe
    idleWrite(9, 39'h01_0000_0000);       // clears error
    runCmd(2047, 39'h05_5555_0000, 1000);
    runCmd(0, 39'h22_0000_0000, 2047);
    for (int n = 0; n < 25; n++) begin
      int          c = $urandom_range(1, 40);
      logic [38:0] a = 39'({$urandom, $urandom});
      int          inj = ($urandom % 3 == 0) ? $urandom_range(0, c - 1) : -1;
      runCmd(c, a, inj);
    end
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog R5 actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule